// File: doc/BRIEF.md
# Win-by-Two Match Announcer

This block follows a two-player rally game one point at a time and reports when the game ends and which player took it. Each point event is a one-cycle strobe together with one bit naming the player who scored. Every event gives exactly one point to one of the two players. The machine stores no full scores. It keeps only how far one player is ahead of the other, which is -1, 0 or +1 while the game is in play. A player who goes two points ahead wins the game.

Five states cover a game of any length. Three are in play: player 2 ahead by one, tied, and player 1 ahead by one. The other two are terminal states, one for each winner. Once the machine enters a terminal state it ignores all further point strobes until reset. The `win` and `winner` outputs are registered and change on the same edge as the state. A synchronous reset returns the machine to the tied start and has priority over a point strobe in the same cycle.

A parameter selects how the state is stored: a compact binary register or a one-hot register.

Top module: `win_announcer`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to the tied state and both `win` and `winner` read 0 after that edge, even if `point_valid` is high in the same cycle.
- R2: A rising edge with `point_valid` low leaves the state and both outputs unchanged.
- R3: `scorer` = 0 gives the point to player 1. From tied this moves to player 1 ahead by one. From player 2 ahead by one it moves back to tied. Neither move raises `win`.
- R4: `scorer` = 1 gives the point to player 2. From tied this moves to player 2 ahead by one. From player 1 ahead by one it moves back to tied. Neither move raises `win`.
- R5: A point to player 1 while player 1 is ahead by one sets `win` = 1 and `winner` = 0 on that same edge.
- R6: A point to player 2 while player 2 is ahead by one sets `win` = 1 and `winner` = 1 on that same edge.
- R7: After a win, point strobes have no effect. `win` stays 1 and `winner` keeps its value until a reset.
- R8: `winner` reads 0 whenever `win` is 0.
- R9: The score sequence player 2, player 1, player 1, player 1 (scores 0:1, 1:1, 2:1, 3:1) raises `win` only after the fourth point and names player 1 as the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset to the tied start |
| point_valid | input | 1 | One-cycle strobe: a point was scored this cycle |
| scorer | input | 1 | Player who scored: 0 = player 1, 1 = player 2 |
| win | output | 1 | High once either player has won |
| winner | output | 1 | Winning player: 0 = player 1, 1 = player 2 (0 while `win` is low) |

## Verification
Reset and a point strobe can arrive in the same cycle. The bench provokes this twice: during the opening reset, and again just after a finished game. In both cases it expects the tie state with both outputs low, and no point counted. A late strobe that lands on a terminal state is a second collision. The bench sends points of both kinds after each win and expects the winner to stay unchanged.

// File: rtl/announcer_pkg.sv
package announcer_pkg;

   // Logical game states. The enum value is also the one-hot bit index.
   typedef enum logic [2:0] {
      ST_P2_AHEAD = 3'd0,
      ST_EVEN     = 3'd1,
      ST_P1_AHEAD = 3'd2,
      ST_P1_WON   = 3'd3,
      ST_P2_WON   = 3'd4
   } rally_state_e;

   localparam int  NUM_STATES  = 5;
   localparam int  BIN_WIDTH   = $clog2(NUM_STATES);
   localparam logic SCORER_P1  = 1'b0;
   localparam logic SCORER_P2  = 1'b1;

   function automatic logic is_terminal(input rally_state_e s);
      return (s == ST_P1_WON) || (s == ST_P2_WON);
   endfunction

endpackage

// File: rtl/announcer_step.sv
module announcer_step
   import announcer_pkg::*;
(
   input  rally_state_e cur,
   input  logic         point_valid,
   input  logic         scorer,
   output rally_state_e nxt
);

   always_comb begin
      nxt = cur;
      if (point_valid) begin
         case (cur)
            ST_EVEN:     nxt = (scorer == SCORER_P2) ? ST_P2_AHEAD : ST_P1_AHEAD;
            ST_P1_AHEAD: nxt = (scorer == SCORER_P2) ? ST_EVEN     : ST_P1_WON;
            ST_P2_AHEAD: nxt = (scorer == SCORER_P2) ? ST_P2_WON   : ST_EVEN;
            default:     nxt = cur;   // terminal states absorb points
         endcase
      end
   end

endmodule

// File: rtl/announcer_state_reg.sv
module announcer_state_reg
   import announcer_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
)(
   input  logic         clk,
   input  logic         rst,
   input  rally_state_e nxt,
   output rally_state_e cur
);

   localparam int SW = ONE_HOT ? NUM_STATES : BIN_WIDTH;

   generate
      if (ONE_HOT) begin : g_onehot
         logic [SW-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) q <= SW'(1) << int'(ST_EVEN);
            else     q <= SW'(1) << int'(nxt);
         end
         always_comb begin
            cur = ST_EVEN;
            for (int i = 0; i < SW; i++)
               if (q[i]) cur = rally_state_e'(3'(i));
         end

         // R1: the one-hot register never holds more or fewer than one bit
         a_r1_onehot_legal: assert property (@(posedge clk) disable iff (rst)
            $onehot(q));
      end else begin : g_binary
         logic [SW-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) q <= SW'(ST_EVEN);
            else     q <= SW'(nxt);
         end
         assign cur = rally_state_e'(q);

         // R1: the binary code always names one of the five states
         a_r1_binary_legal: assert property (@(posedge clk) disable iff (rst)
            q < SW'(NUM_STATES));
      end
   endgenerate

endmodule

// File: rtl/announcer_outputs.sv
module announcer_outputs
   import announcer_pkg::*;
(
   input  logic         clk,
   input  logic         rst,
   input  rally_state_e nxt,
   output logic         win,
   output logic         winner
);

   always_ff @(posedge clk) begin
      if (rst) begin
         win    <= 1'b0;
         winner <= 1'b0;
      end else begin
         win    <= is_terminal(nxt);
         winner <= (nxt == ST_P2_WON);
      end
   end

   // R8: winner identity is masked while no game is decided
   a_r8_winner_masked: assert property (@(posedge clk) disable iff (rst)
      !win |-> !winner);

endmodule

// File: rtl/win_announcer.sv
module win_announcer
   import announcer_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
)(
   input  logic clk,
   input  logic rst,
   input  logic point_valid,
   input  logic scorer,
   output logic win,
   output logic winner
);

   generate
      if (NUM_STATES != 5) begin : g_bad_states
         $error("win_announcer: state count must be five");
      end
   endgenerate

   rally_state_e cur_st, nxt_st;

   announcer_step u_step (
      .cur         (cur_st),
      .point_valid (point_valid),
      .scorer      (scorer),
      .nxt         (nxt_st)
   );

   announcer_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   announcer_outputs u_out (
      .clk    (clk),
      .rst    (rst),
      .nxt    (nxt_st),
      .win    (win),
      .winner (winner)
   );

   // R1: reset wins over any strobe in the same cycle
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!win && !winner && cur_st == ST_EVEN));

   // R2: an edge without a strobe holds the state
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !point_valid |=> $stable(cur_st));

   // R5: player 1 converts a one-point lead
   a_r5_p1_wins: assert property (@(posedge clk) disable iff (rst)
      (cur_st == ST_P1_AHEAD && point_valid && scorer == SCORER_P1) |=> (win && !winner));

   // R6: player 2 converts a one-point lead
   a_r6_p2_wins: assert property (@(posedge clk) disable iff (rst)
      (cur_st == ST_P2_AHEAD && point_valid && scorer == SCORER_P2) |=> (win && winner));

   // R7: a decided game stays decided until reset
   a_r7_sticky_win: assert property (@(posedge clk) disable iff (rst)
      win |=> (win && $stable(winner)));

endmodule

// File: tb/test_win_announcer.sv
`timescale 1ns/1ps
module test_win_announcer;

   logic clk = 1'b0;
   logic rst, point_valid, scorer;
   logic win, winner;

   always #2 clk = ~clk;   // 250 MHz

   win_announcer i_win_announcer (
      .clk         (clk),
      .rst         (rst),
      .point_valid (point_valid),
      .scorer      (scorer),
      .win         (win),
      .winner      (winner)
   );

   typedef struct {
      logic  exp_win;
      logic  exp_winner;
      string tag;
   } exp_item_t;

   exp_item_t sb_q[$];
   int tests_run = 0;
   int tests_failed = 0;
   bit finished = 1'b0;

   // Reference model: score difference, positive means player 1 ahead
   int  mdl_diff = 0;
   bit  mdl_done = 1'b0;

   // Driver: applies one cycle of stimulus at the falling edge
   task automatic drive(input logic r, input logic v, input logic s, input string tag);
      exp_item_t it;
      @(negedge clk);
      rst = r; point_valid = v; scorer = s;
      if (r) begin
         mdl_diff = 0; mdl_done = 1'b0;
      end else if (v && !mdl_done) begin
         mdl_diff += (s ? -1 : 1);
         if (mdl_diff == 2 || mdl_diff == -2) mdl_done = 1'b1;
      end
      it.exp_win    = mdl_done;
      it.exp_winner = mdl_done && (mdl_diff < 0);
      it.tag        = tag;
      sb_q.push_back(it);
   endtask

   task automatic pt(input logic s, input string tag);
      drive(1'b0, 1'b1, s, tag);
   endtask

   task automatic idle(input string tag);
      drive(1'b0, 1'b0, 1'b0, tag);
   endtask

   // Monitor: compares one result per edge, just after the edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_item_t it;
         it = sb_q.pop_front();
         tests_run++;
         if (win !== it.exp_win || winner !== it.exp_winner) begin
            tests_failed++;
            $display("FAIL %s: win/winner=%b%b expected %b%b",
                     it.tag, win, winner, it.exp_win, it.exp_winner);
         end
      end
   end

   initial begin
      rst = 1'b1; point_valid = 1'b1; scorer = 1'b0;
      // R1: reset with strobes active in the same cycles
      drive(1'b1, 1'b1, 1'b0, "R1 reset with p1 strobe");
      drive(1'b1, 1'b1, 1'b1, "R1 reset with p2 strobe");
      idle("R2 idle after reset");

      // R9: the worked example 0:1 1:1 2:1 3:1, with idle gaps
      pt(1'b1, "R9 step 0:1 R4");
      idle("R2 idle in play");
      pt(1'b0, "R9 step 1:1 R3");
      pt(1'b0, "R9 step 2:1 R3");
      idle("R2 idle at lead");
      pt(1'b0, "R9 step 3:1 R5");
      // R7: later points of both kinds are ignored
      pt(1'b1, "R7 p2 after p1 win");
      pt(1'b1, "R7 p2 after p1 win");
      pt(1'b0, "R7 p1 after p1 win");
      idle("R7 idle after win");
      // R1: reset and strobe together after a win
      drive(1'b1, 1'b1, 1'b0, "R1 reset over strobe after win");

      // R3 R4 R8: long rally with many returns to tie
      for (int k = 0; k < 20; k++) begin
         pt(1'b0, "R3 p1 leads");
         pt(1'b1, "R4 back to tie");
      end
      for (int k = 0; k < 10; k++) begin
         pt(1'b1, "R4 p2 leads");
         pt(1'b0, "R3 back to tie");
      end
      pt(1'b1, "R4 p2 leads late");
      pt(1'b1, "R6 p2 wins");
      pt(1'b0, "R7 p1 after p2 win");
      pt(1'b0, "R7 p1 after p2 win");
      pt(1'b1, "R7 p2 after p2 win");
      drive(1'b1, 1'b0, 1'b0, "R1 reset after p2 win");
      idle("R8 winner low after reset");

      // R5: a direct p1 win from the tie
      pt(1'b0, "R3 p1 leads");
      pt(1'b0, "R5 p1 direct win");
      drive(1'b1, 1'b0, 1'b0, "R1 reset");
      pt(1'b1, "R4 p2 leads");
      pt(1'b0, "R3 tie from p2 lead");
      pt(1'b0, "R3 p1 leads");
      pt(1'b1, "R4 tie from p1 lead");
      idle("R2 idle at tie");

      @(negedge clk);
      point_valid = 1'b0; rst = 1'b0;
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: run incomplete, expected finish");
         $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

endmodule